// File: doc/BRIEF.md
# Banked Video Memory Window Mapper

This block sits between a CPU bus and four byte-wide external SRAM chips of 32 KB each. A 4 KB window at CPU address 0xC000 shows one of 32 SRAM pages, or an internal 512-byte palette. A six-bit bank register makes the choice. The chips are interleaved one byte at a time. Window offset bits [1:0] pick the chip. Within a chip, each 128-byte region holds a 4-byte slice of every page, and the slices are stored in page order. Each chip therefore carries one quarter of every page, which is 1024 bytes per page.

For every CPU access the block works out a chip select and a 15-bit chip offset. It drives the enable and the write strobe of exactly one chip and returns that chip's byte in the same cycle. When the palette bank is selected, the access goes to on-block storage and no chip is enabled. Palette reads are registered, so their data returns one cycle later.

A small state machine tracks that extra cycle. There are two states:
- `ST_IDLE`: accesses are accepted. The transition *pal_read_issue* goes to `ST_PAL_RD` on a palette read; every other access stays in `ST_IDLE`.
- `ST_PAL_RD`: the registered palette byte is presented. The transition *pal_data_done* always returns to `ST_IDLE` after one cycle. Any request made during this state is dropped.

Top module: `vbm_mapper`

## Requirements
- R1: After reset, the bank register holds 0, all chip enables and write strobes are low, and `cpu_rvalid` is low.
- R2: When the selected bank is 0..31 (bit 5 clear), a request inside the window raises exactly one chip enable. The enable is `sram_ce[cpu_addr[1:0]]`. A write also raises the matching `sram_we` bit and drives `cpu_wdata` onto `sram_wdata`. Write strobes are never high without their enable.
- R3: For page p and window offset o = `cpu_addr[11:0]`, `sram_addr` equals {o[11:4], p[4:0], o[3:2]}.
- R4: An SRAM read returns byte `sram_rdata[8*k+7:8*k]` of the selected chip k on `cpu_rdata`. `cpu_rvalid` is high in the same cycle as the request.
- R5: Bank value 32 selects the palette for window offsets 0x000..0x1FF, and no chip enable is raised. A palette write stores the byte. A palette read presents the stored byte with `cpu_rvalid` one cycle after the request.
- R6: Bank values 33..63, and palette-bank offsets 0x200..0xFFF, are unmapped. Reads there return 0xFF with `cpu_rvalid` in the same cycle. Writes there change no palette byte, and no chip is enabled.
- R7: Requests whose `cpu_addr[15:12]` is not 0xC raise no chip enable and no `cpu_rvalid`.
- R8: A bank write takes effect from the next cycle. An access issued in the same cycle as the bank write uses the old bank.
- R9: A request issued in the cycle after a palette read (state `ST_PAL_RD`) is ignored. No chip is enabled, no palette byte is written, and the pending palette data is still returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 6 | New bank value |
| cpu_req | input | 1 | Access request for this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read byte |
| cpu_rvalid | output | 1 | Read byte valid this cycle |
| sram_ce | output | 4 | Per-chip enable, active high |
| sram_we | output | 4 | Per-chip write strobe, active high |
| sram_addr | output | 15 | Shared chip offset |
| sram_wdata | output | 8 | Shared chip write byte |
| sram_rdata | input | 32 | Chip read bytes, chip k at bits 8k+7:8k |

## Verification
The following results appear in the request cycle itself:
- chip enables, strobes, chip offset and write data;
- SRAM and unmapped read data.

The bench therefore drives each request just after a falling edge and samples these results 1 ns later, before the next rising edge. Palette read data and its valid flag come one rising edge later, so the bench checks them after the following falling edge. A bank write is checked twice: on an access in the same cycle, which must still use the old page, and on the access in the next cycle.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SRAM,
        ACC_PAL,
        ACC_VOID
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE,
        ST_PAL_RD
    } mapper_state_t;
endpackage

// File: rtl/vbm_bank_reg.sv
module vbm_bank_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] bank
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bank <= '0;
        else if (we) bank <= wdata;
    end

    // R8: the bank only changes on a register write
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank));
endmodule

// File: rtl/vbm_xlate.sv
module vbm_xlate
    import vbm_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         WIN_AW    = 12,
    parameter int         PAGE_BITS = 5,
    parameter int         PAL_AW    = 9,
    parameter logic [3:0] WIN_BASE  = 4'hC,
    localparam int        TAG_W     = ADDR_W - WIN_AW,
    localparam int        CHIP_AW   = WIN_AW - 2 + PAGE_BITS
) (
    input  logic                 req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [PAGE_BITS:0]   bank,
    output acc_kind_t            kind,
    output logic [1:0]           chip_sel,
    output logic [CHIP_AW-1:0]   chip_off,
    output logic [PAL_AW-1:0]    pal_idx
);
    localparam logic [PAGE_BITS:0] PAL_BANK = (PAGE_BITS+1)'(1) << PAGE_BITS;

    logic [WIN_AW-1:0] off;
    logic              in_win;
    logic              pal_range;

    assign off       = addr[WIN_AW-1:0];
    assign in_win    = (addr[ADDR_W-1:WIN_AW] == TAG_W'(WIN_BASE));
    assign pal_range = (off[WIN_AW-1:PAL_AW] == '0);
    assign chip_sel  = off[1:0];
    assign chip_off  = {off[WIN_AW-1:4], bank[PAGE_BITS-1:0], off[3:2]};
    assign pal_idx   = off[PAL_AW-1:0];

    always_comb begin
        if (!req || !in_win)          kind = ACC_NONE;
        else if (!bank[PAGE_BITS])    kind = ACC_SRAM;
        else if (bank == PAL_BANK)    kind = pal_range ? ACC_PAL : ACC_VOID;
        else                          kind = ACC_VOID;
    end
endmodule

// File: rtl/vbm_palette.sv
module vbm_palette #(
    parameter int AW = 9,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) mem[idx] <= wdata;
        if (rd) rdata <= mem[idx];
    end

    // R5: one palette access per cycle, read or write
    p_one_port_r5: assert final (!(wr && rd));
endmodule

// File: rtl/vbm_mapper.sv
module vbm_mapper
    import vbm_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         WIN_AW    = 12,
    parameter int         PAGE_BITS = 5,
    parameter int         PAL_AW    = 9,
    parameter logic [3:0] WIN_BASE  = 4'hC,
    localparam int        CHIPS     = 4,
    localparam int        CHIP_AW   = WIN_AW - 2 + PAGE_BITS,
    localparam int        BANK_W    = PAGE_BITS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bank_we,
    input  logic [BANK_W-1:0]    bank_wdata,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [7:0]           cpu_wdata,
    output logic [7:0]           cpu_rdata,
    output logic                 cpu_rvalid,
    output logic [CHIPS-1:0]     sram_ce,
    output logic [CHIPS-1:0]     sram_we,
    output logic [CHIP_AW-1:0]   sram_addr,
    output logic [7:0]           sram_wdata,
    input  logic [8*CHIPS-1:0]   sram_rdata
);
    mapper_state_t       state_q, state_d;
    acc_kind_t           kind, acc;
    logic [BANK_W-1:0]   bank_q;
    logic [1:0]          chip_sel;
    logic [CHIP_AW-1:0]  chip_off;
    logic [PAL_AW-1:0]   pal_idx;
    logic [7:0]          pal_rdata;
    logic [7:0]          chip_byte;
    logic                pal_wr, pal_rd;

    vbm_bank_reg #(.W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(bank_wdata), .bank(bank_q)
    );

    vbm_xlate #(
        .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .PAGE_BITS(PAGE_BITS),
        .PAL_AW(PAL_AW), .WIN_BASE(WIN_BASE)
    ) u_xlate (
        .req(cpu_req), .addr(cpu_addr), .bank(bank_q), .kind(kind),
        .chip_sel(chip_sel), .chip_off(chip_off), .pal_idx(pal_idx)
    );

    vbm_palette #(.AW(PAL_AW)) u_pal (
        .clk(clk), .wr(pal_wr), .rd(pal_rd), .idx(pal_idx),
        .wdata(cpu_wdata), .rdata(pal_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: pal_read_issue / pal_data_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (kind == ACC_PAL && !cpu_we) state_d = ST_PAL_RD;
            ST_PAL_RD: state_d = ST_IDLE;
        endcase
    end

    // selected chip's read byte
    always_comb begin
        chip_byte = '0;
        for (int k = 0; k < CHIPS; k++)
            if (chip_sel == 2'(k)) chip_byte = sram_rdata[8*k +: 8];
    end

    // outputs
    always_comb begin
        acc        = ACC_NONE;
        cpu_rdata  = 8'hFF;
        cpu_rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc = kind;
                if (kind == ACC_SRAM && !cpu_we) begin
                    cpu_rdata  = chip_byte;
                    cpu_rvalid = 1'b1;
                end else if (kind == ACC_VOID && !cpu_we) begin
                    cpu_rvalid = 1'b1;
                end
            end
            ST_PAL_RD: begin
                cpu_rdata  = pal_rdata;
                cpu_rvalid = 1'b1;
            end
        endcase
        sram_ce    = (acc == ACC_SRAM) ? (CHIPS'(1) << chip_sel) : '0;
        sram_we    = cpu_we ? sram_ce : '0;
        sram_addr  = chip_off;
        sram_wdata = cpu_wdata;
        pal_wr     = (acc == ACC_PAL) && cpu_we;
        pal_rd     = (acc == ACC_PAL) && !cpu_we;
    end

    // ---------------- assertions ----------------
    logic in_win_p;
    assign in_win_p = (cpu_addr[ADDR_W-1:WIN_AW] == (ADDR_W-WIN_AW)'(WIN_BASE));

    p_one_chip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && in_win_p && !bank_q[PAGE_BITS])
        |-> (sram_ce[cpu_addr[1:0]] && $countones(sram_ce) == 1));

    p_we_in_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we & ~sram_ce) == '0);

    p_pal_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q[PAGE_BITS] |-> (sram_ce == '0));

    p_pal_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !cpu_we && in_win_p &&
         bank_q == BANK_W'(1 << PAGE_BITS) && cpu_addr[WIN_AW-1:PAL_AW] == '0)
        |=> cpu_rvalid);

    p_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cpu_req && !in_win_p)
        |-> (sram_ce == '0 && !cpu_rvalid));

    p_gap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAL_RD) |-> (sram_ce == '0 && sram_we == '0));
endmodule

// File: tb/vbm_mapper_test.sv
`timescale 1ns/1ps
module vbm_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_we = 1'b0;
    logic [5:0]  bank_wdata = '0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic [3:0]  sram_ce, sram_we;
    logic [14:0] sram_addr;
    logic [7:0]  sram_wdata;
    logic [31:0] sram_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] pal_exp [512];

    always #2.5 clk = ~clk;

    vbm_mapper uut (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .sram_ce(sram_ce), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    function automatic logic [7:0] mdl(input int k, input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'(8'h5A + k * 17);
    endfunction

    for (genvar k = 0; k < 4; k++) begin : g_chip
        assign sram_rdata[8*k +: 8] = mdl(k, sram_addr);
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (addr %h)", rq, act, exp, cpu_addr);
        end
    endtask

    task automatic drive(input logic r, input logic [15:0] a, input logic w, input logic [7:0] d);
        @(negedge clk);
        bank_we = 1'b0; cpu_req = r; cpu_addr = a; cpu_we = w; cpu_wdata = d;
        #1;
    endtask

    task automatic set_bank(input logic [5:0] v);
        @(negedge clk);
        cpu_req = 1'b0; bank_we = 1'b1; bank_wdata = v;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    function automatic logic [14:0] xoff(input logic [4:0] p, input logic [11:0] o);
        return {o[11:4], p, o[3:2]};
    endfunction

    // checks one SRAM access in its request cycle (R2, R3, R4)
    task automatic sram_access(input logic [4:0] p, input logic [11:0] o, input logic w, input logic [7:0] d);
        logic [3:0] ece;
        drive(1'b1, 16'hC000 | 16'(o), w, d);
        ece = 4'b0001 << o[1:0];
        chk(sram_ce == ece && sram_we == (w ? ece : 4'b0), "R2 chip strobes", {sram_ce, sram_we}, {ece, w ? ece : 4'b0});
        chk(sram_addr == xoff(p, o), "R3 chip offset", sram_addr, xoff(p, o));
        if (w) chk(sram_wdata == d, "R2 write data", sram_wdata, d);
        else   chk(cpu_rvalid && cpu_rdata == mdl(o[1:0], xoff(p, o)), "R4 sram read",
                   {cpu_rvalid, cpu_rdata}, {1'b1, mdl(o[1:0], xoff(p, o))});
    endtask

    task automatic pal_read(input logic [8:0] i, input string rq);
        drive(1'b1, 16'hC000 | 16'(i), 1'b0, 8'h00);
        chk(sram_ce == 4'b0, {rq, " no chip"}, sram_ce, 0);
        drive(1'b0, 16'h0000, 1'b0, 8'h00);
        chk(cpu_rvalid && cpu_rdata == pal_exp[i], rq, {cpu_rvalid, cpu_rdata}, {1'b1, pal_exp[i]});
    endtask

    task automatic void_access(input logic [11:0] o, input logic w, input string rq);
        drive(1'b1, 16'hC000 | 16'(o), w, 8'hA5);
        chk(sram_ce == 4'b0 && sram_we == 4'b0, {rq, " no chip"}, {sram_ce, sram_we}, 0);
        if (!w) chk(cpu_rvalid && cpu_rdata == 8'hFF, {rq, " read FF"}, {cpu_rvalid, cpu_rdata}, 9'h1FF);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pages [5] = '{0, 1, 17, 30, 31};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(sram_ce == 0 && sram_we == 0 && !cpu_rvalid, "R1 quiet after reset", {sram_ce, sram_we, cpu_rvalid}, 0);
        sram_access(5'd0, 12'h005, 1'b0, 8'h00); // R1 bank 0

        // R2/R3/R4 full read sweeps over several pages
        foreach (pages[j]) begin
            set_bank(6'(pages[j]));
            for (int o = 0; o < 4096; o++) sram_access(5'(pages[j]), 12'(o), 1'b0, 8'h00);
        end
        // writes over a full page
        set_bank(6'd5);
        for (int o = 0; o < 4096; o++) sram_access(5'd5, 12'(o), 1'b1, 8'(o * 3 + 1));
        // every page, strided offsets
        for (int p = 0; p < 32; p++) begin
            set_bank(6'(p));
            for (int o = 0; o < 4096; o += 257) sram_access(5'(p), 12'(o), o[0], 8'(p + o));
        end

        // R7 outside the window
        for (int a = 0; a < 65536; a += 331) begin
            if (a[15:12] != 4'hC) begin
                drive(1'b1, 16'(a), a[1], 8'h3C);
                chk(sram_ce == 0 && !cpu_rvalid, "R7 outside window", {sram_ce, cpu_rvalid}, 0);
            end
        end

        // R5 palette write all, read all
        set_bank(6'd32);
        for (int i = 0; i < 512; i++) begin
            pal_exp[i] = 8'(i * 7 + 3);
            drive(1'b1, 16'hC000 | 16'(i), 1'b1, pal_exp[i]);
            chk(sram_ce == 0 && sram_we == 0, "R5 palette write no chip", {sram_ce, sram_we}, 0);
        end
        for (int i = 0; i < 512; i++) pal_read(9'(i), "R5 palette read");

        // R6 palette bank above 0x1FF, then unmapped banks
        for (int o = 512; o < 4096; o += 61) void_access(12'(o), o[0], "R6 high offset");
        void_access(12'h200, 1'b1, "R6 alias write");
        set_bank(6'd33);
        for (int o = 0; o < 512; o += 13) void_access(12'(o), 1'b1, "R6 bank 33");
        void_access(12'h000, 1'b0, "R6 bank 33");
        set_bank(6'd63);
        for (int o = 0; o < 4096; o += 97) void_access(12'(o), o[1], "R6 bank 63");
        set_bank(6'd32);
        for (int i = 0; i < 512; i += 13) pal_read(9'(i), "R6 palette untouched");

        // R9 request in the return cycle is dropped
        drive(1'b1, 16'hC005, 1'b0, 8'h00);
        drive(1'b1, 16'hC005, 1'b1, 8'hEE);
        chk(cpu_rvalid && cpu_rdata == pal_exp[5], "R9 pending data kept", cpu_rdata, pal_exp[5]);
        chk(sram_ce == 0, "R9 no chip", sram_ce, 0);
        pal_read(9'd5, "R9 palette not written");
        set_bank(6'd9);
        drive(1'b0, 16'h0, 1'b0, 8'h0);
        set_bank(6'd32);
        drive(1'b1, 16'hC010, 1'b0, 8'h00);
        drive(1'b1, 16'hC013, 1'b0, 8'h00);
        chk(sram_ce == 0 && cpu_rdata == pal_exp[16], "R9 read ignored", {sram_ce, cpu_rdata}, {4'b0, pal_exp[16]});

        // R8 bank write timing
        set_bank(6'd31);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = 6'd4;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'hC01E;
        #1;
        chk(sram_addr == xoff(5'd31, 12'h01E), "R8 same cycle old bank", sram_addr, xoff(5'd31, 12'h01E));
        sram_access(5'd4, 12'h01E, 1'b0, 8'h00); // R8 new bank next cycle
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = 6'd32;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'hC001;
        #1;
        chk(sram_ce == 4'b0010, "R8 switch to palette uses old bank", sram_ce, 4'b0010);
        drive(1'b1, 16'hC001, 1'b0, 8'h00);
        chk(sram_ce == 0, "R8 palette active next cycle", sram_ce, 0);
        drive(1'b0, 16'h0, 1'b0, 8'h00);
        chk(cpu_rvalid && cpu_rdata == pal_exp[1], "R8 palette data", cpu_rdata, pal_exp[1]);

        drive(1'b0, 16'h0, 1'b0, 8'h00);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule